// File: doc/BRIEF.md
# Wake-up and Watchdog Reset Supervisor

This block supervises a microcontroller that spends most of its time asleep. It drives a continuous square wave whose rising edges wake the controller. Once awake, the controller answers with a falling edge on a watchdog line. That answer ends the current high phase early. A cycle that passes without an answer produces a reset pulse. After that pulse, a fixed quiet interval passes before the wave starts again.

The block also owns the active-low reset for supply problems. An external comparator, which already applies hysteresis, reports whether the supply is in regulation. While that flag is low, reset is held asserted. Once the flag returns, reset stays low for one more short interval.

All intervals are counted in units of one base duration, and their ratios are fixed. A wake cycle lasts eight units, half of them high. The reset pulse lasts one unit. The gap from reset release to the first wake edge is four units. One unit is `TICK_CYCLES * UNIT_TICKS` clock cycles, so the unit can be made very short in simulation.

Top module: `wake_watchdog_sup`

## Requirements
- R1: While the asynchronous reset is applied, and afterwards until the supply flag is seen high, `rstN` and `wakeUp` are both 0.
- R2: A clock edge that samples `supplyOk` low makes `rstN` and `wakeUp` 0 from that edge on. Both stay 0 for every later edge that also samples it low, whatever state the wake cycle was in.
- R3: The first edge that samples `supplyOk` high starts the reset interval. `rstN` then rises exactly one unit (U clock cycles) after that edge.
- R4: When `rstN` rises, `wakeUp` stays 0 for exactly four units. It then rises, and that rising edge starts a wake cycle.
- R5: A wake cycle lasts eight units. If no watchdog falling edge is seen, `wakeUp` is 1 for the first four units and 0 for the last four. The next cycle then starts with a rising edge.
- R6: `wdi` passes through a two-stage synchronizer. Only a 1-to-0 change of the synchronized value counts; rising edges count for nothing. The first counted edge in a cycle forces `wakeUp` to 0 within three clock edges of `wdi` being sampled low. `wakeUp` then stays 0 until the next cycle starts.
- R7: Further watchdog falling edges inside the same cycle change neither `wakeUp` nor `rstN`.
- R8: A cycle that ends with no counted watchdog edge drops `rstN` to 0 for exactly one unit at the cycle boundary. The R4 sequence follows. `wakeUp` is 0 whenever `rstN` is 0.
- R9: Watchdog edges seen while `rstN` is 0, or during the four-unit gap, do not count for the next cycle.
- R10: A supply drop in the middle of a cycle aborts the cycle and any pending watchdog outcome. When the supply returns, only the one-unit reset interval of R3 applies before R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arstN | input | 1 | Asynchronous reset, active low |
| supplyOk | input | 1 | Supply-in-regulation flag, synchronous to clk |
| wdi | input | 1 | Watchdog input from the controller, asynchronous |
| rstN | output | 1 | Reset to the controller, active low |
| wakeUp | output | 1 | Wake-up square wave |

## Verification
The assertions assume that `supplyOk` is synchronous to the clock and carries no glitches shorter than a cycle, because its comparator already applies hysteresis. They also assume that `wdi` holds each level for at least two cycles, so the synchronizer cannot swallow a pulse. The stimulus changes `supplyOk` and `wdi` only on falling clock edges. Every watchdog pulse it sends holds low and high for at least three cycles. It also shifts the pulse timing from cycle to cycle, so that pulses land in the high phase, the low phase, the reset interval and the quiet gap.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,   // supply out of regulation
    ST_RDLY  = 3'd1,   // reset pulse interval
    ST_GAP   = 3'd2,   // reset released, wake still quiet
    ST_CYCLE = 3'd3    // running wake cycle
  } supState_t;

  typedef struct packed {
    logic clrTimer;    // restart prescaler and tick counter
    logic clrSeen;     // forget any watchdog edge
  } supStrobe_t;

endpackage

// File: rtl/sup_timebase.sv
module sup_timebase
  import sup_pkg::*;
#(
  parameter int TICK_CYCLES = 1000,
  parameter int MAX_TICKS   = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CW          = $clog2(MAX_TICKS + 1)
) (
  input  logic          clk,
  input  logic          arstN,
  input  supStrobe_t    stb,
  input  logic          wdiRaw,
  output logic          tick,
  output logic [CW-1:0] tickCnt,
  output logic          fall,
  output logic          seen
);

  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int SH = SYNC_STAGES + 1;

  logic [PW-1:0] preCnt;
  logic [SH-1:0] syncSh;

  assign tick = (preCnt == PW'(TICK_CYCLES - 1));

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (stb.clrTimer) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (tick) begin
      preCnt  <= '0;
      tickCnt <= tickCnt + 1'b1;
    end else begin
      preCnt  <= preCnt + 1'b1;
    end
  end

  // synchronizer stages plus one history stage for edge detection
  genvar g;
  generate
    for (g = 0; g < SH; g++) begin : gSync
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN)  syncSh[g] <= 1'b0;
        else if (g == 0) syncSh[g] <= wdiRaw;
        else syncSh[g] <= syncSh[g-1];
      end
    end
  endgenerate

  assign fall = syncSh[SH-1] & ~syncSh[SH-2];

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)           seen <= 1'b0;
    else if (stb.clrSeen) seen <= 1'b0;
    else if (fall)        seen <= 1'b1;
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!arstN)
    tickCnt < CW'(MAX_TICKS));

  // R9
  seen_clear_chk: assert property (@(posedge clk) disable iff (!arstN)
    stb.clrSeen |=> !seen);

endmodule

// File: rtl/sup_control.sv
module sup_control
  import sup_pkg::*;
#(
  parameter int UNIT_TICKS = 2,
  parameter int CW         = 5
) (
  input  logic          clk,
  input  logic          arstN,
  input  logic          supplyOk,
  input  logic          tick,
  input  logic [CW-1:0] tickCnt,
  input  logic          fall,
  input  logic          seen,
  output supStrobe_t    stb,
  output logic          rstN,
  output logic          wakeUp
);

  localparam int RST_TICKS  = UNIT_TICKS;
  localparam int GAP_TICKS  = 4 * UNIT_TICKS;
  localparam int CYC_TICKS  = 8 * UNIT_TICKS;
  localparam int HIGH_TICKS = CYC_TICKS / 2;

  supState_t state, stateNx;
  logic      phaseEnd;
  logic [CW-1:0] lastTick;

  always_comb begin
    case (state)
      ST_RDLY:  lastTick = CW'(RST_TICKS - 1);
      ST_GAP:   lastTick = CW'(GAP_TICKS - 1);
      default:  lastTick = CW'(CYC_TICKS - 1);
    endcase
  end

  assign phaseEnd = tick && (tickCnt == lastTick);

  always_comb begin
    stateNx = state;
    if (!supplyOk) begin
      stateNx = ST_HOLD;
    end else begin
      case (state)
        ST_HOLD:  stateNx = ST_RDLY;
        ST_RDLY:  if (phaseEnd) stateNx = ST_GAP;
        ST_GAP:   if (phaseEnd) stateNx = ST_CYCLE;
        ST_CYCLE: if (phaseEnd) stateNx = (seen || fall) ? ST_CYCLE : ST_RDLY;
        default:  stateNx = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= ST_HOLD;
    else        state <= stateNx;
  end

  always_comb begin
    stb.clrTimer = (state == ST_HOLD) || phaseEnd;
    stb.clrSeen  = (state != ST_CYCLE) || phaseEnd;
  end

  assign rstN   = (state == ST_GAP) || (state == ST_CYCLE);
  assign wakeUp = (state == ST_CYCLE) && (tickCnt < CW'(HIGH_TICKS)) && !seen;

  // R2
  supply_drop_chk: assert property (@(posedge clk) disable iff (!arstN)
    !supplyOk |=> (!rstN && !wakeUp));

  // R8
  wake_quiet_chk: assert property (@(posedge clk) disable iff (!arstN)
    !rstN |-> !wakeUp);

  // R3
  release_supply_chk: assert property (@(posedge clk) disable iff (!arstN)
    $rose(rstN) |-> $past(supplyOk));

  // R4
  wake_start_chk: assert property (@(posedge clk) disable iff (!arstN)
    $rose(wakeUp) |-> (tickCnt == '0 && $past(rstN)));

endmodule

// File: rtl/wake_watchdog_sup.sv
module wake_watchdog_sup
  import sup_pkg::*;
#(
  parameter int TICK_CYCLES = 1000,
  parameter int UNIT_TICKS  = 5
) (
  input  logic clk,
  input  logic arstN,
  input  logic supplyOk,
  input  logic wdi,
  output logic rstN,
  output logic wakeUp
);

  localparam int MAX_TICKS = 8 * UNIT_TICKS;
  localparam int CW        = $clog2(MAX_TICKS + 1);

  supStrobe_t    stb;
  logic          tick, fall, seen;
  logic [CW-1:0] tickCnt;

  sup_timebase #(
    .TICK_CYCLES(TICK_CYCLES),
    .MAX_TICKS  (MAX_TICKS),
    .SYNC_STAGES(2),
    .CW         (CW)
  ) uTime (
    .clk(clk), .arstN(arstN), .stb(stb), .wdiRaw(wdi),
    .tick(tick), .tickCnt(tickCnt), .fall(fall), .seen(seen)
  );

  sup_control #(
    .UNIT_TICKS(UNIT_TICKS),
    .CW        (CW)
  ) uCtrl (
    .clk(clk), .arstN(arstN), .supplyOk(supplyOk),
    .tick(tick), .tickCnt(tickCnt), .fall(fall), .seen(seen),
    .stb(stb), .rstN(rstN), .wakeUp(wakeUp)
  );

endmodule

// File: tb/sim_wake_watchdog_sup.sv
`timescale 1ns/100ps
module sim_wake_watchdog_sup;

  localparam int P    = 3;
  localparam int U    = 2;
  localparam int UNIT = P * U;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic supplyOk = 1'b0;
  logic wdi = 1'b1;
  logic rstN, wakeUp;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";
  bit done = 0;

  wake_watchdog_sup #(.TICK_CYCLES(P), .UNIT_TICKS(U)) u0 (
    .clk(clk), .arstN(arstN), .supplyOk(supplyOk), .wdi(wdi),
    .rstN(rstN), .wakeUp(wakeUp)
  );

  always #2.5 clk = ~clk;

  // behavioural reference: phase number and elapsed clock count
  int mPhase = 0;    // 0 hold, 1 reset pulse, 2 gap, 3 cycle
  int mCount = 0;
  bit mSeen = 0;
  bit q1 = 0, q2 = 0, q3 = 0;

  always @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      mPhase = 0; mCount = 0; mSeen = 0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      bit fallNow;
      fallNow = q3 && !q2;
      if (!supplyOk) begin
        mPhase = 0; mCount = 0; mSeen = 0;
      end else if (mPhase == 0) begin
        mPhase = 1; mCount = 0; mSeen = 0;
      end else if (mPhase == 1) begin
        if (mCount == UNIT - 1) begin mPhase = 2; mCount = 0; end
        else mCount++;
        mSeen = 0;
      end else if (mPhase == 2) begin
        if (mCount == 4 * UNIT - 1) begin mPhase = 3; mCount = 0; end
        else mCount++;
        mSeen = 0;
      end else begin
        if (mCount == 8 * UNIT - 1) begin
          mPhase = (mSeen || fallNow) ? 3 : 1;
          mCount = 0; mSeen = 0;
        end else begin
          mCount++;
          mSeen = mSeen || fallNow;
        end
      end
      q3 = q2; q2 = q1; q1 = wdi;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit eR, eW;
      eR = (mPhase >= 2);
      eW = (mPhase == 3) && (mCount < 4 * UNIT) && !mSeen;
      compared++;
      if (rstN !== eR || wakeUp !== eW) begin
        mismatched++;
        $display("FAIL %s t=%0t rstN=%b wakeUp=%b expected rstN=%b wakeUp=%b",
                 tag, $time, rstN, wakeUp, eR, eW);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input int lowCyc);
    @(negedge clk); wdi = 1'b0;
    waitCyc(lowCyc);
    wdi = 1'b1;
    waitCyc(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state and supply not yet good
    tag = "R1";
    waitCyc(4);
    arstN = 1'b1;
    waitCyc(10);
    // R3: reset release after one unit
    tag = "R3";
    supplyOk = 1'b1;
    waitCyc(UNIT + 4);
    // R4: quiet gap before first wake edge
    tag = "R4";
    waitCyc(4 * UNIT + 4);
    // R6: answer each cycle at different offsets, high and low phases
    tag = "R6";
    for (int i = 0; i < 6; i++) begin
      waitCyc(3 + 5 * i);
      kick(3);
      waitCyc(8 * UNIT - 9 - 5 * i);
    end
    // R5: regular answers late in the low phase keep cycles running
    tag = "R5";
    for (int i = 0; i < 4; i++) begin
      waitCyc(8 * UNIT - 8);
      kick(3);
      waitCyc(2);
    end
    // R7: bursts of pulses inside each cycle
    tag = "R7";
    for (int i = 0; i < 5; i++) begin
      kick(3); kick(4); kick(3);
      waitCyc(8 * UNIT - 20);
    end
    // R8: silence ends a cycle with a reset pulse
    tag = "R8";
    waitCyc(20 * UNIT);
    // R9: pulses while reset or gap is active must not count
    tag = "R9";
    for (int i = 0; i < 12; i++) begin
      if (!rstN || !wakeUp) kick(3);
      else waitCyc(3);
    end
    waitCyc(20 * UNIT);
    // R10: supply drop mid-cycle aborts everything
    tag = "R10";
    @(negedge clk);
    while (!wakeUp) @(negedge clk);
    waitCyc(5);
    supplyOk = 1'b0;
    waitCyc(4);
    supplyOk = 1'b1;
    waitCyc(UNIT + 4 * UNIT + 10);
    kick(3);
    waitCyc(8 * UNIT);
    // R2: long supply loss while running
    tag = "R2";
    waitCyc(7);
    supplyOk = 1'b0;
    kick(3);
    waitCyc(30);
    supplyOk = 1'b1;
    waitCyc(6 * UNIT);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule